// File: doc/BRIEF.md
# Half-Word Logical Shifter with Signed Count

This block shifts one 16-bit half of a 32-bit source word by a signed amount and writes the result into a chosen half of a 32-bit destination word. The sign of the count sets the direction. A positive count moves bits toward the most significant end. A negative count moves them toward bit 0 and fills with zeros. The half of the destination that is not written keeps the value presented on the destination input.

The source half and the destination half are picked independently. The shift amount is taken from a 16-bit count half-word. The caller presents the current destination word together with the operands. When the valid strobe is high, the updated word is captured in an output register on the rising clock edge. Because every operand is sampled in the same cycle, a source that is also the destination or the count register is read at its original value.

Top module: `hw_lshift_unit`

## Requirements
- R1: A positive count n (1..15) shifts the 16-bit operand left by n bits. Bits pushed above bit 15 are lost, with no saturation. For example, 0x0003 by 15 gives 0x8000 and 0xC001 by 1 gives 0x8002.
- R2: A negative count -n (1..15) shifts the operand right by n bits and inserts zeros at bit 15. For example, 0x8001 by -1 gives 0x4000 and 0x8007 by -1 gives 0x4003.
- R3: A count of -15 moves the original bit 15 into bit 0 and clears every other bit. For example, 0x9005 gives 0x0001.
- R4: A count whose magnitude is 16 or more gives 0x0000. This covers +16, +31, -16 and -32.
- R5: A count of 0 returns the operand unchanged.
- R6: When `src_hi_i`=1 the operand is source bits [31:16]. When `src_hi_i`=0 it is bits [15:0].
- R7: When `dst_hi_i`=1 the result goes to bits [31:16] and bits [15:0] come from `dst_word_i`. When `dst_hi_i`=0 the result goes to bits [15:0] and bits [31:16] come from `dst_word_i`.
- R8: Only count bits [5:0] are used, read as a two's-complement value from -32 to 31. Bits [15:6] have no effect. For example, 0x0041 acts as +1 and 0x7FFF acts as -1.
- R9: `result_o` is loaded on a rising edge where `valid_i`=1, so it shows the new word one cycle after the inputs are presented. It holds its value while `valid_i`=0.
- R10: A rising edge with `rst_n`=0 clears `result_o` to 0x00000000. This reset takes priority over `valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Capture the updated word on this edge |
| src_word_i | input | 32 | Source register value |
| src_hi_i | input | 1 | Source half select: 1 = high, 0 = low |
| cnt_half_i | input | 16 | Count half-word; bits [5:0] are the signed count |
| dst_word_i | input | 32 | Current destination register value |
| dst_hi_i | input | 1 | Destination half select: 1 = high, 0 = low |
| result_o | output | 32 | Registered updated destination word |

## Verification
The clocked properties assume that all operand inputs are stable around the edge where `valid_i` is high. They also assume that `valid_i` is low while reset is held. The stimulus changes inputs only on the falling edge and keeps `valid_i` at 0 throughout the initial reset. The one exception is a deliberate mid-run reset with `valid_i` high, used to show that reset wins. The properties that compare against `$past` of the inputs rely on those inputs being held for the whole cycle, and the bench's drive-on-falling-edge discipline guarantees that.

// File: rtl/hwsh_pkg.sv
// Shared types for the half-word shifter.
// Assumes: a half select is a single bit, high half = 1.
package hwsh_pkg;
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;
endpackage

// File: rtl/hwsh_half_pick.sv
// Selects one half of a double-width word as the shift operand.
// Assumes: the word is exactly two halves of HALF_W bits.
module hwsh_half_pick
    import hwsh_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word_i,
    input  logic                sel_i,
    output logic [HALF_W-1:0]   half_o
);
    half_sel_e sel;

    // Decode the select bit into the package type.
    assign sel = half_sel_e'(sel_i);

    // Route the chosen half to the operand.
    always_comb begin
        if (sel == HALF_HI) half_o = word_i[2*HALF_W-1:HALF_W];
        else                half_o = word_i[HALF_W-1:0];
    end
endmodule

// File: rtl/hwsh_cnt_decode.sv
// Turns the count half-word into a direction, a per-stage magnitude
// and a kill flag for magnitudes that shift everything out.
// Assumes: the count field is the low CNT_BITS bits, two's complement.
module hwsh_cnt_decode #(
    parameter int HALF_W   = 16,
    parameter int CNT_BITS = 6,
    parameter int STG      = $clog2(HALF_W)
) (
    input  logic [HALF_W-1:0] cnt_half_i,
    output logic              left_o,
    output logic [STG-1:0]    mag_o,
    output logic              kill_o
);
    localparam logic [CNT_BITS-1:0] LIMIT = CNT_BITS'(HALF_W);

    logic [CNT_BITS-1:0] field;
    logic [CNT_BITS-1:0] mag_full;
    logic                neg;
    logic                unused_upper;

    // Extract the signed field; the upper count bits are ignored.
    assign field        = cnt_half_i[CNT_BITS-1:0];
    assign unused_upper = ^cnt_half_i[HALF_W-1:CNT_BITS];
    assign neg          = field[CNT_BITS-1];

    // Absolute value of the count (the most negative value maps to 2^(CNT_BITS-1)).
    assign mag_full = neg ? (~field + 1'b1) : field;

    // Direction, staged magnitude and the shift-out condition.
    assign left_o = ~neg;
    assign mag_o  = mag_full[STG-1:0];
    assign kill_o = (mag_full >= LIMIT);
endmodule

// File: rtl/hwsh_barrel.sv
// Logarithmic bidirectional logical shifter on one half-word.
// Assumes: mag_i < HALF_W whenever kill_i is low; zero fill both ways.
module hwsh_barrel #(
    parameter int HALF_W = 16,
    parameter int STG    = $clog2(HALF_W)
) (
    input  logic [HALF_W-1:0] op_i,
    input  logic              left_i,
    input  logic [STG-1:0]    mag_i,
    input  logic              kill_i,
    output logic [HALF_W-1:0] res_o
);
    logic [HALF_W-1:0] stage [0:STG];

    assign stage[0] = op_i;

    // One conditional power-of-two shift per magnitude bit.
    for (genvar i = 0; i < STG; i++) begin : g_stage
        localparam int SH = 1 << i;
        assign stage[i+1] = mag_i[i]
                          ? (left_i ? (stage[i] << SH) : (stage[i] >> SH))
                          : stage[i];
    end

    // Force zero when the magnitude clears the whole half-word.
    assign res_o = kill_i ? '0 : stage[STG];
endmodule

// File: rtl/hwsh_half_merge.sv
// Writes a new half into a double-width word and keeps the other half.
// Assumes: sel_i = 1 writes the high half.
module hwsh_half_merge
    import hwsh_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word_i,
    input  logic                sel_i,
    input  logic [HALF_W-1:0]   half_i,
    output logic [2*HALF_W-1:0] word_o
);
    half_sel_e sel;

    // Decode the select bit into the package type.
    assign sel = half_sel_e'(sel_i);

    // Splice the new half in beside the preserved one.
    always_comb begin
        if (sel == HALF_HI) word_o = {half_i, word_i[HALF_W-1:0]};
        else                word_o = {word_i[2*HALF_W-1:HALF_W], half_i};
    end
endmodule

// File: rtl/hw_lshift_unit.sv
// Top of the half-word logical shifter: pick operand, decode count,
// shift, merge into destination, register on valid.
// Assumes: inputs are stable across the capturing edge; reset is
// synchronous and active low.
module hw_lshift_unit #(
    parameter int HALF_W   = 16,
    parameter int CNT_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [2*HALF_W-1:0] src_word_i,
    input  logic                src_hi_i,
    input  logic [HALF_W-1:0]   cnt_half_i,
    input  logic [2*HALF_W-1:0] dst_word_i,
    input  logic                dst_hi_i,
    output logic [2*HALF_W-1:0] result_o
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int STG    = $clog2(HALF_W);

    logic [HALF_W-1:0] operand;
    logic [HALF_W-1:0] shifted;
    logic [WORD_W-1:0] merged;
    logic              left;
    logic [STG-1:0]    mag;
    logic              kill;

    hwsh_half_pick #(.HALF_W(HALF_W)) u_pick (
        .word_i (src_word_i),
        .sel_i  (src_hi_i),
        .half_o (operand)
    );

    hwsh_cnt_decode #(.HALF_W(HALF_W), .CNT_BITS(CNT_BITS), .STG(STG)) u_dec (
        .cnt_half_i (cnt_half_i),
        .left_o     (left),
        .mag_o      (mag),
        .kill_o     (kill)
    );

    hwsh_barrel #(.HALF_W(HALF_W), .STG(STG)) u_shift (
        .op_i   (operand),
        .left_i (left),
        .mag_i  (mag),
        .kill_i (kill),
        .res_o  (shifted)
    );

    hwsh_half_merge #(.HALF_W(HALF_W)) u_merge (
        .word_i (dst_word_i),
        .sel_i  (dst_hi_i),
        .half_i (shifted),
        .word_o (merged)
    );

    // Output register: clear on reset, load on valid, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       result_o <= '0;
        else if (valid_i) result_o <= merged;
    end

    // R10: reset clears the output on the following edge.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0));

    // R9: no strobe, no change.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o));

    // R7: high-half write keeps the low half of the destination.
    a_r7_keep_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dst_hi_i) |=> (result_o[HALF_W-1:0] == $past(dst_word_i[HALF_W-1:0])));

    // R7: low-half write keeps the high half of the destination.
    a_r7_keep_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dst_hi_i) |=> (result_o[WORD_W-1:HALF_W] == $past(dst_word_i[WORD_W-1:HALF_W])));

    // R4: a shift-out count writes zero into the low half.
    a_r4_kill_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kill && !dst_hi_i) |=> (result_o[HALF_W-1:0] == '0));

    // R5: a zero count writes the picked operand unchanged.
    a_r5_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (cnt_half_i[CNT_BITS-1:0] == '0) && !dst_hi_i)
        |=> (result_o[HALF_W-1:0] == $past(operand)));
endmodule

// File: tb/hw_lshift_unit_tb.sv
`timescale 1ns/1ps
module hw_lshift_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] src_word_i = '0;
    logic        src_hi_i = 1'b0;
    logic [15:0] cnt_half_i = '0;
    logic [31:0] dst_word_i = '0;
    logic        dst_hi_i = 1'b0;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hw_lshift_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .src_word_i (src_word_i),
        .src_hi_i   (src_hi_i),
        .cnt_half_i (cnt_half_i),
        .dst_word_i (dst_word_i),
        .dst_hi_i   (dst_hi_i),
        .result_o   (result_o)
    );

    // Vector: {req[3:0], src[31:0], src_hi, cnt[15:0], dst[31:0], dst_hi, exp[31:0]}
    localparam int NV = 18;
    localparam logic [117:0] VEC [NV] = '{
        {4'd2,  32'h0000_8001, 1'b0, 16'hFFFF, 32'h0000_0000, 1'b0, 32'h0000_4000},
        {4'd2,  32'h0000_8007, 1'b0, 16'hFFFF, 32'h0000_0000, 1'b0, 32'h0000_4003},
        {4'd3,  32'h0000_9005, 1'b0, 16'hFFF1, 32'h0000_0000, 1'b0, 32'h0000_0001},
        {4'd3,  32'h0000_A001, 1'b0, 16'hFFF1, 32'h0000_0000, 1'b0, 32'h0000_0001},
        {4'd4,  32'h0000_FFFF, 1'b0, 16'hFFF0, 32'h0000_0000, 1'b0, 32'h0000_0000},
        {4'd5,  32'h8001_0000, 1'b1, 16'h0000, 32'h8001_0000, 1'b0, 32'h8001_8001},
        {4'd6,  32'h8001_0000, 1'b1, 16'hFFFF, 32'h8001_0000, 1'b1, 32'h4000_0000},
        {4'd7,  32'h0000_9001, 1'b0, 16'hFFF1, 32'h0000_9001, 1'b1, 32'h0001_9001},
        {4'd1,  32'h0000_0003, 1'b0, 16'h0004, 32'h0000_0000, 1'b0, 32'h0000_0030},
        {4'd1,  32'h0000_C001, 1'b0, 16'h0001, 32'h0000_0000, 1'b0, 32'h0000_8002},
        {4'd1,  32'h0000_0003, 1'b0, 16'h000F, 32'h0000_0000, 1'b0, 32'h0000_8000},
        {4'd4,  32'h0000_FFFF, 1'b0, 16'h0010, 32'h0000_0000, 1'b0, 32'h0000_0000},
        {4'd4,  32'h0000_FFFF, 1'b0, 16'h001F, 32'h0000_0000, 1'b0, 32'h0000_0000},
        {4'd4,  32'h0000_FFFF, 1'b0, 16'h0020, 32'h0000_0000, 1'b0, 32'h0000_0000},
        {4'd8,  32'h0000_0005, 1'b0, 16'h0041, 32'h0000_0000, 1'b0, 32'h0000_000A},
        {4'd8,  32'h0000_8001, 1'b0, 16'h7FFF, 32'h0000_0000, 1'b0, 32'h0000_4000},
        {4'd7,  32'h0000_0001, 1'b0, 16'h0004, 32'hABCD_1234, 1'b0, 32'hABCD_0010},
        {4'd6,  32'h1234_0000, 1'b1, 16'hFFFC, 32'hABCD_1234, 1'b1, 32'h0123_1234}
    };

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Present one operation at a falling edge; sample one falling edge later.
    task automatic apply(input logic [31:0] s, input logic sh, input logic [15:0] c,
                         input logic [31:0] d, input logic dh);
        @(negedge clk);
        src_word_i = s; src_hi_i = sh; cnt_half_i = c;
        dst_word_i = d; dst_hi_i = dh; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: output cleared by reset
        check("R10", result_o, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][113:82], VEC[k][81], VEC[k][80:65], VEC[k][64:33], VEC[k][32]);
            check(tag(VEC[k][117:114]), result_o, VEC[k][31:0]);
        end

        // R9: load, then change inputs with valid low; output must hold
        apply(32'h0000_00F0, 1'b0, 16'h0001, 32'h0000_0000, 1'b0);
        check("R9", result_o, 32'h0000_01E0);
        src_word_i = 32'hFFFF_FFFF; cnt_half_i = 16'h0000; dst_word_i = 32'h5555_5555;
        repeat (2) @(negedge clk);
        check("R9", result_o, 32'h0000_01E0);

        // R10: reset beats a simultaneous valid strobe
        @(negedge clk);
        rst_n = 1'b0; valid_i = 1'b1;
        @(negedge clk);
        check("R10", result_o, 32'h0);
        valid_i = 1'b0; rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule